// File: doc/BRIEF.md
# Descriptor Ring Prefetch and Writeback Controller

This block sits between a network interface engine and a ring of 16-byte DMA descriptors in host memory. It holds the ring base address, ring length, head and tail indices, and a prefetch pointer. It also keeps a small local cache that counts descriptors that have been fetched but not consumed ("unused") and descriptors that have been consumed but not written back ("used"). When the tail moves ahead of the prefetch pointer and the cache has free slots, the block issues one burst read request for a run of descriptors. When the engine asks for a writeback, the block issues one burst write request that returns consumed descriptors to memory. When that write completes, the block advances the head.

The consumer takes descriptors one at a time through a valid/ready handshake. Each descriptor it takes moves from the unused pool to the used pool, and the block reports the ring index of the descriptor being offered. A writeback burst is shortened in two cases: it stops at the ring end, and it can be trimmed to a multiple set by an alignment mask. If a request with a looser mask arrives while a writeback is in flight, the block queues it and reissues it after the current burst completes. Each DMA channel uses a one-cycle request pulse carrying address and count, followed later by a one-cycle completion pulse.

Top module: `desc_ring_cache`

## Requirements
- R1: The ring length in descriptors is the written byte length shifted right by 4 (field `cfgData[IDX_W+3:4]`). Every DMA address is the base plus the ring index times 16. Configuration selects are: 0 base, 1 byte length, 2 head, 3 tail.
- R2: The fetch count is computed in two steps. If tail ≥ prefetch pointer, it is tail − pointer; otherwise it is ring length − pointer. The result is then capped at the free cache slots (CACHE_SLOTS − used − unused). A request appears on `rdReq` one cycle after the decision.
- R3: No fetch is issued while a fetch is outstanding, and none is issued when the computed count is zero.
- R4: A fetch completion adds the count to the unused pool and advances the prefetch pointer by the count. The pointer becomes 0 when it reaches the ring length.
- R5: `popValid` is high whenever the unused pool is non-empty. Each accepted pop moves one entry to the used pool (`descUsed`). `popIdx` steps through ring indices in order and wraps to 0 at the ring length.
- R6: The writeback count is computed in one of three ways. If used + head ≥ ring length, the count is ring length − head and a follow-on is flagged. Otherwise, with a nonzero mask, the count is used AND NOT mask. With a zero mask, the count is used. A count of zero issues nothing.
- R7: A writeback request that arrives while a writeback is outstanding, with a mask smaller than the stored one, issues nothing. It stores the new mask and flags a follow-on.
- R8: A writeback completion advances the head by the burst count, subtracting the ring length on wrap. If a follow-on is flagged, the block re-evaluates the writeback with the stored mask on the next cycle.
- R9: With IRQ_ON_WB set, `wbIrq` pulses for one cycle after each writeback completion.
- R10: A write of base, length or head is handled in one of two ways. If used entries, a fetch or a writeback are outstanding, the write is rejected and `cfgErr` pulses for one cycle. Otherwise the write empties both pools and sets the prefetch pointer and pop index to 0. Tail writes are always accepted.
- R11: `descLeft` equals unused + |prefetch pointer − tail|.
- R12: After reset, no request is pending, both pools are empty, and head, tail and pointer are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target (0 base, 1 byte length, 2 head, 3 tail) |
| cfgData | input | ADDR_W | Configuration write data |
| rdReq | output | 1 | Descriptor fetch request pulse |
| rdAddr | output | ADDR_W | Fetch byte address |
| rdCount | output | CNT_W | Fetch count in descriptors |
| rdDone | input | 1 | Fetch completion pulse |
| wrReq | output | 1 | Descriptor writeback request pulse |
| wrAddr | output | ADDR_W | Writeback byte address |
| wrCount | output | CNT_W | Writeback count in descriptors |
| wrDone | input | 1 | Writeback completion pulse |
| wbReq | input | 1 | Writeback request from the engine |
| wbMask | input | IDX_W | Alignment mask for the writeback request |
| popValid | output | 1 | An unused descriptor is available |
| popReady | input | 1 | Consumer takes the offered descriptor |
| popIdx | output | IDX_W | Ring index of the offered descriptor |
| ringHead | output | IDX_W | Current head index |
| descLeft | output | IDX_W+1 | Descriptors left, as defined in R11 |
| descUsed | output | CNT_W | Used entries not yet written back |
| wbIrq | output | 1 | Writeback-done interrupt request pulse |
| cfgErr | output | 1 | Illegal reconfiguration pulse |

## Verification
The checks assume the following about the inputs:
- `rdDone` and `wrDone` arrive only while the matching request is outstanding.
- The head and tail stay below the ring length.
- `wbReq` and a configuration write never share a cycle with `wrDone`.

The stimulus drives every input on the falling edge from sequential tasks. Each completion is given only after the bench has observed the request pulse, and every configured index is kept inside the ring. The bench runs a table of ring layouts covering head, tail, pop count and mask, and then runs directed sequences for the prefetch wrap, the queued follow-on, and both legal and rejected reconfiguration.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_HEAD = 2'd2,
    SEL_TAIL = 2'd3
  } cfgSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fetchIssue;
    logic fetchDone;
    logic wbIssue;
    logic wbDone;
    logic popTake;
    logic cfgAccept;
    logic cfgReject;
    logic cacheClear;
  } ringStrobe_t;
endpackage

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
#(
  parameter int CACHE_SLOTS = 16,
  parameter int IDX_W       = 12,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgSel,
  input  logic             rdDone,
  input  logic             wrDone,
  input  logic             wbReq,
  input  logic [IDX_W-1:0] wbMask,
  input  logic             popReady,
  input  logic [IDX_W-1:0] ringLen,
  input  logic [IDX_W-1:0] ringHead,
  input  logic [IDX_W-1:0] ringTail,
  input  logic [IDX_W-1:0] prePtr,
  input  logic [CNT_W-1:0] unusedCnt,
  input  logic [CNT_W-1:0] usedCnt,
  output ringStrobe_t      stb,
  output logic [CNT_W-1:0] fetchCnt,
  output logic [CNT_W-1:0] wbCnt
);
  localparam int SW = IDX_W + 1;

  logic             fetchBusy, wbBusy, moreWb, retryWb;
  logic [IDX_W-1:0] keptMask;

  logic             structWrite, illegal;
  logic [IDX_W-1:0] rawFetch;
  logic [CNT_W-1:0] freeSlots;
  logic             wbTrig, queueOnly, reachEnd;
  logic [IDX_W-1:0] effMask;
  logic [SW-1:0]    endSum;

  always_comb begin
    structWrite = cfgWrEn && (cfgSel != SEL_TAIL);
    illegal     = structWrite && ((usedCnt != '0) || fetchBusy || wbBusy);

    rawFetch  = (ringTail >= prePtr) ? (ringTail - prePtr) : (ringLen - prePtr);
    freeSlots = CNT_W'(CACHE_SLOTS) - usedCnt - unusedCnt;
    fetchCnt  = (rawFetch < IDX_W'(freeSlots)) ? CNT_W'(rawFetch) : freeSlots;

    wbTrig    = wbReq || retryWb;
    effMask   = wbReq ? wbMask : keptMask;
    queueOnly = wbTrig && wbBusy && (effMask < keptMask);
    endSum    = SW'(ringHead) + SW'(usedCnt);
    reachEnd  = endSum >= SW'(ringLen);
    if (reachEnd)             wbCnt = CNT_W'(ringLen - ringHead);
    else if (effMask != '0)   wbCnt = usedCnt & ~CNT_W'(effMask);
    else                      wbCnt = usedCnt;

    stb.cfgAccept  = cfgWrEn && !illegal;
    stb.cfgReject  = illegal;
    stb.cacheClear = structWrite && !illegal;
    stb.fetchIssue = !fetchBusy && !cfgWrEn && (fetchCnt != '0);
    stb.fetchDone  = rdDone && fetchBusy;
    stb.wbIssue    = wbTrig && !queueOnly && !wbBusy && !cfgWrEn && (wbCnt != '0);
    stb.wbDone     = wrDone && wbBusy;
    stb.popTake    = popReady && (unusedCnt != '0) && !stb.cacheClear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchBusy <= 1'b0;
      wbBusy    <= 1'b0;
      moreWb    <= 1'b0;
      retryWb   <= 1'b0;
      keptMask  <= '0;
    end else begin
      if (stb.fetchIssue)     fetchBusy <= 1'b1;
      else if (stb.fetchDone) fetchBusy <= 1'b0;

      if (stb.wbIssue)        wbBusy <= 1'b1;
      else if (stb.wbDone)    wbBusy <= 1'b0;

      if (wbTrig) begin
        keptMask <= effMask;
        moreWb   <= queueOnly ? 1'b1 : reachEnd;
        retryWb  <= 1'b0;
      end else if (stb.wbDone) begin
        retryWb  <= moreWb;
      end
    end
  end
endmodule

// File: rtl/desc_ring_path.sv
module desc_ring_path
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 12,
  parameter int CNT_W     = 5,
  parameter bit IRQ_ON_WB = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       stb,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [CNT_W-1:0]  fetchCnt,
  input  logic [CNT_W-1:0]  wbCnt,
  output logic [IDX_W-1:0]  ringLen,
  output logic [IDX_W-1:0]  ringHead,
  output logic [IDX_W-1:0]  ringTail,
  output logic [IDX_W-1:0]  prePtr,
  output logic [CNT_W-1:0]  unusedCnt,
  output logic [CNT_W-1:0]  usedCnt,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdCount,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [CNT_W-1:0]  wrCount,
  output logic              popValid,
  output logic [IDX_W-1:0]  popIdx,
  output logic [IDX_W:0]    descLeft,
  output logic              wbIrq,
  output logic              cfgErr
);
  localparam int SW = IDX_W + 1;

  logic [ADDR_W-1:0] ringBase;
  logic [CNT_W-1:0]  flightFetch, flightWb;
  logic [SW-1:0]     ptrSum, headSum, consSum;
  logic [IDX_W-1:0]  gap;

  always_comb begin
    ptrSum   = SW'(prePtr) + SW'(flightFetch);
    headSum  = SW'(ringHead) + SW'(flightWb);
    consSum  = SW'(popIdx) + SW'(1);
    gap      = (prePtr >= ringTail) ? (prePtr - ringTail) : (ringTail - prePtr);
    descLeft = SW'(unusedCnt) + SW'(gap);
    popValid = unusedCnt != '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringBase <= '0; ringLen <= '0; ringHead <= '0; ringTail <= '0;
      prePtr <= '0; unusedCnt <= '0; usedCnt <= '0; popIdx <= '0;
      flightFetch <= '0; flightWb <= '0;
      rdReq <= 1'b0; rdAddr <= '0; rdCount <= '0;
      wrReq <= 1'b0; wrAddr <= '0; wrCount <= '0;
      cfgErr <= 1'b0;
    end else begin
      cfgErr <= stb.cfgReject;
      if (stb.cfgAccept) begin
        case (cfgSel)
          SEL_BASE: ringBase <= cfgData;
          SEL_LEN:  ringLen  <= cfgData[IDX_W+3:4];
          SEL_HEAD: ringHead <= cfgData[IDX_W-1:0];
          default:  ringTail <= cfgData[IDX_W-1:0];
        endcase
      end
      if (stb.cacheClear) begin
        unusedCnt <= '0;
        usedCnt   <= '0;
        prePtr    <= '0;
        popIdx    <= '0;
      end else begin
        unusedCnt <= unusedCnt + (stb.fetchDone ? flightFetch : '0) - CNT_W'(stb.popTake);
        usedCnt   <= usedCnt + CNT_W'(stb.popTake) - (stb.wbIssue ? wbCnt : '0);
        if (stb.fetchDone)
          prePtr <= (ptrSum == SW'(ringLen)) ? '0 : ptrSum[IDX_W-1:0];
        if (stb.popTake)
          popIdx <= (consSum == SW'(ringLen)) ? '0 : consSum[IDX_W-1:0];
      end
      if (stb.wbDone)
        ringHead <= (headSum >= SW'(ringLen)) ? IDX_W'(headSum - SW'(ringLen))
                                              : headSum[IDX_W-1:0];

      rdReq <= stb.fetchIssue;
      if (stb.fetchIssue) begin
        flightFetch <= fetchCnt;
        rdCount     <= fetchCnt;
        rdAddr      <= ringBase + (ADDR_W'(prePtr) << 4);
      end
      wrReq <= stb.wbIssue;
      if (stb.wbIssue) begin
        flightWb <= wbCnt;
        wrCount  <= wbCnt;
        wrAddr   <= ringBase + (ADDR_W'(ringHead) << 4);
      end
    end
  end

  generate
    if (IRQ_ON_WB) begin : gIrq
      always_ff @(posedge clk) begin
        if (!rstN) wbIrq <= 1'b0;
        else       wbIrq <= stb.wbDone;
      end
    end else begin : gNoIrq
      assign wbIrq = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/desc_ring_cache.sv
module desc_ring_cache
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 12,
  parameter int CACHE_SLOTS = 16,
  parameter bit IRQ_ON_WB   = 1'b1,
  localparam int CNT_W      = $clog2(CACHE_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdCount,
  input  logic              rdDone,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [CNT_W-1:0]  wrCount,
  input  logic              wrDone,
  input  logic              wbReq,
  input  logic [IDX_W-1:0]  wbMask,
  output logic              popValid,
  input  logic              popReady,
  output logic [IDX_W-1:0]  popIdx,
  output logic [IDX_W-1:0]  ringHead,
  output logic [IDX_W:0]    descLeft,
  output logic [CNT_W-1:0]  descUsed,
  output logic              wbIrq,
  output logic              cfgErr
);
  ringStrobe_t      stb;
  logic [CNT_W-1:0] fetchCnt, wbCnt, unusedCnt;
  logic [IDX_W-1:0] ringLen, ringTail, prePtr;

  desc_ring_ctrl #(.CACHE_SLOTS(CACHE_SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) uCtrl (
    .clk, .rstN, .cfgWrEn, .cfgSel, .rdDone, .wrDone, .wbReq, .wbMask, .popReady,
    .ringLen, .ringHead, .ringTail, .prePtr, .unusedCnt, .usedCnt(descUsed),
    .stb, .fetchCnt, .wbCnt
  );

  desc_ring_path #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .IRQ_ON_WB(IRQ_ON_WB)) uPath (
    .clk, .rstN, .stb, .cfgSel, .cfgData, .fetchCnt, .wbCnt,
    .ringLen, .ringHead, .ringTail, .prePtr, .unusedCnt, .usedCnt(descUsed),
    .rdReq, .rdAddr, .rdCount, .wrReq, .wrAddr, .wrCount,
    .popValid, .popIdx, .descLeft, .wbIrq, .cfgErr
  );
endmodule

// File: rtl/desc_ring_chk.sv
module desc_ring_chk #(
  parameter int CACHE_SLOTS = 16,
  parameter int IDX_W       = 12,
  parameter int CNT_W       = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdReq,
  input logic             rdDone,
  input logic [CNT_W-1:0] rdCount,
  input logic             wrReq,
  input logic             wrDone,
  input logic [CNT_W-1:0] wrCount,
  input logic [CNT_W-1:0] descUsed,
  input logic [IDX_W-1:0] ringHead,
  input logic             wbIrq,
  input logic             cfgErr,
  input logic             cfgWrEn
);
  logic fBusy, wBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fBusy <= 1'b0;
      wBusy <= 1'b0;
    end else begin
      fBusy <= (fBusy || rdReq) && !rdDone;
      wBusy <= (wBusy || wrReq) && !wrDone;
    end
  end

  a_r3_single_fetch: assert property (@(posedge clk) disable iff (!rstN)
    fBusy |-> !rdReq);
  a_r2_fetch_fits: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (rdCount != '0) && ((CNT_W+1)'(rdCount) + (CNT_W+1)'(descUsed) <= (CNT_W+1)'(CACHE_SLOTS)));
  a_r6_wb_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> wrCount != '0);
  a_r7_single_wb: assert property (@(posedge clk) disable iff (!rstN)
    wBusy |-> !wrReq);
  a_r9_irq_after_done: assert property (@(posedge clk) disable iff (!rstN)
    wbIrq |-> $past(wrDone));
  a_r10_err_from_cfg: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> $past(cfgWrEn));
  a_r8_head_moves_on_done: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrDone) && !$past(cfgWrEn)) |-> $stable(ringHead));
endmodule

bind desc_ring_cache desc_ring_chk #(.CACHE_SLOTS(CACHE_SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdDone(rdDone), .rdCount(rdCount),
  .wrReq(wrReq), .wrDone(wrDone), .wrCount(wrCount), .descUsed(descUsed),
  .ringHead(ringHead), .wbIrq(wbIrq), .cfgErr(cfgErr), .cfgWrEn(cfgWrEn)
);

// File: tb/sim_desc_ring_cache.sv
`timescale 1ns/1ps
module sim_desc_ring_cache;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 12;
  localparam int CNT_W  = 5;
  localparam int WDOG   = 20000;

  // columns: len, head, tail, pops, mask, expFetch, expWb, expHeadAfter, expFollow
  localparam int NV = 5;
  localparam int VEC [0:NV-1][0:8] = '{
    '{64, 0, 10,  7, 0, 10, 7, 7, 0},
    '{64, 0, 10,  7, 3, 10, 4, 4, 0},
    '{64, 0, 40, 13, 7, 16, 8, 8, 0},
    '{ 8, 5,  6,  4, 1,  6, 3, 0, 0},
    '{ 8, 6,  5,  3, 0,  5, 2, 0, 1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [ADDR_W-1:0] cfgData = '0;
  logic rdDone = 1'b0, wrDone = 1'b0, wbReq = 1'b0, popReady = 1'b0;
  logic [IDX_W-1:0] wbMask = '0;
  logic rdReq, wrReq, popValid, wbIrq, cfgErr;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [CNT_W-1:0] rdCount, wrCount, descUsed;
  logic [IDX_W-1:0] popIdx, ringHead;
  logic [IDX_W:0] descLeft;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int fCnt;
  longint fAddr;

  always #2.5 clk = ~clk;

  desc_ring_cache u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      checks = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog: run hung act=%0d exp<%0d", cyc, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; cfgWrEn = 1'b0; rdDone = 1'b0; wrDone = 1'b0;
    wbReq = 1'b0; popReady = 1'b0; wbMask = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input longint data);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = ADDR_W'(data);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // waits for a fetch request; optionally answers it
  task automatic waitFetch(input bit answer, output int cnt, output longint addr);
    cnt = -1; addr = -1;
    for (int i = 0; i < 20; i++) begin
      if (rdReq) break;
      @(negedge clk);
    end
    if (rdReq) begin
      cnt = int'(rdCount); addr = longint'(rdAddr);
      if (answer) begin
        rdDone = 1'b1;
        @(negedge clk);
        rdDone = 1'b0;
      end
    end
  endtask

  task automatic popN(input int n, input int start, input int len, input string req);
    popReady = 1'b1;
    for (int i = 0; i < n; i++) begin
      chk(req, "popValid", popValid, 1);
      chk(req, "popIdx", popIdx, (start + i) % len);
      @(negedge clk);
    end
    popReady = 1'b0;
  endtask

  task automatic wbRequest(input int mask);
    wbReq = 1'b1; wbMask = IDX_W'(mask);
    @(negedge clk);
    wbReq = 1'b0;
  endtask

  task automatic wbFinish();
    wrDone = 1'b1;
    @(negedge clk);
    wrDone = 1'b0;
  endtask

  initial begin
    // table-driven writeback scenarios
    for (int v = 0; v < NV; v++) begin
      doReset();
      cfgWrite(2'd0, 'h1000);
      cfgWrite(2'd1, VEC[v][0] * 16);
      cfgWrite(2'd2, VEC[v][1]);
      cfgWrite(2'd3, VEC[v][2]);
      waitFetch(1'b1, fCnt, fAddr);
      chk("R2", "fetch count", fCnt, VEC[v][5]);
      chk("R1", "fetch addr", fAddr, 'h1000);
      popN(VEC[v][3], 0, VEC[v][0], "R5");
      chk("R5", "descUsed", descUsed, VEC[v][3]);
      wbRequest(VEC[v][4]);
      chk("R6", "wrReq", wrReq, 1);
      chk("R6", "wrCount", wrCount, VEC[v][6]);
      chk("R1", "wrAddr", wrAddr, 'h1000 + VEC[v][1] * 16);
      wbFinish();
      chk("R8", "head after wb", ringHead, VEC[v][7]);
      chk("R9", "wbIrq", wbIrq, 1);
      @(negedge clk);
      if (VEC[v][8] != 0) begin
        chk("R8", "follow-on wrReq", wrReq, 1);
        chk("R8", "follow-on count", wrCount, VEC[v][8]);
        chk("R8", "follow-on addr", wrAddr, 'h1000 + VEC[v][7] * 16);
        wbFinish();
      end else begin
        chk("R6", "no zero-count burst", wrReq, 0);
      end
    end

    // R12 reset state
    doReset();
    chk("R12", "rdReq", rdReq, 0);
    chk("R12", "wrReq", wrReq, 0);
    chk("R12", "popValid", popValid, 0);
    chk("R12", "ringHead", ringHead, 0);
    chk("R12", "descUsed", descUsed, 0);
    chk("R12", "descLeft", descLeft, 0);
    chk("R12", "cfgErr", cfgErr, 0);
    chk("R12", "wbIrq", wbIrq, 0);

    // R11 descriptors left, R4 pointer advance
    cfgWrite(2'd0, 'h2000);
    cfgWrite(2'd1, 64 * 16);
    cfgWrite(2'd3, 10);
    waitFetch(1'b1, fCnt, fAddr);
    chk("R11", "descLeft after fetch", descLeft, 10);
    popN(3, 0, 64, "R5");
    chk("R11", "descLeft after pops", descLeft, 7);
    cfgWrite(2'd3, 12);
    chk("R11", "descLeft tail ahead", descLeft, 9);
    waitFetch(1'b1, fCnt, fAddr);
    chk("R4", "second fetch count", fCnt, 2);
    chk("R4", "second fetch addr", fAddr, 'h20A0);
    chk("R11", "descLeft caught up", descLeft, 9);

    // R3 single outstanding fetch, R10 rejected reconfiguration
    doReset();
    cfgWrite(2'd1, 64 * 16);
    cfgWrite(2'd3, 4);
    waitFetch(1'b0, fCnt, fAddr);
    chk("R3", "first fetch count", fCnt, 4);
    @(negedge clk);
    cfgWrite(2'd3, 8);
    chk("R10", "tail write accepted quietly", cfgErr, 0);
    cfgWrite(2'd2, 3);
    chk("R10", "cfgErr on busy head write", cfgErr, 1);
    chk("R10", "head unchanged", ringHead, 0);
    @(negedge clk);
    chk("R10", "cfgErr single pulse", cfgErr, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 4; i++) begin
        if (rdReq) seen++;
        @(negedge clk);
      end
      chk("R3", "no fetch while outstanding", seen, 0);
    end
    rdDone = 1'b1;
    @(negedge clk);
    rdDone = 1'b0;
    waitFetch(1'b1, fCnt, fAddr);
    chk("R3", "fetch after completion count", fCnt, 4);
    chk("R1", "fetch after completion addr", fAddr, 'h40);

    // R4 prefetch pointer wrap, R5 pop index wrap
    doReset();
    cfgWrite(2'd0, 'h1000);
    cfgWrite(2'd1, 8 * 16);
    cfgWrite(2'd3, 6);
    waitFetch(1'b1, fCnt, fAddr);
    popN(6, 0, 8, "R5");
    wbRequest(0);
    chk("R6", "wrCount before ring end", wrCount, 6);
    wbFinish();
    chk("R8", "head after wb", ringHead, 6);
    cfgWrite(2'd3, 2);
    waitFetch(1'b1, fCnt, fAddr);
    chk("R2", "fetch to ring end", fCnt, 2);
    chk("R4", "fetch to ring end addr", fAddr, 'h1060);
    waitFetch(1'b1, fCnt, fAddr);
    chk("R4", "fetch after wrap count", fCnt, 2);
    chk("R4", "fetch after wrap addr", fAddr, 'h1000);
    popN(3, 6, 8, "R5");

    // R7 queued follow-on writeback, R9 interrupt pulse
    doReset();
    cfgWrite(2'd0, 'h3000);
    cfgWrite(2'd1, 64 * 16);
    cfgWrite(2'd3, 12);
    waitFetch(1'b1, fCnt, fAddr);
    popN(10, 0, 64, "R5");
    wbRequest(7);
    chk("R6", "masked count", wrCount, 8);
    popN(2, 10, 64, "R5");
    wbRequest(0);
    chk("R7", "queued request issues nothing", wrReq, 0);
    wbFinish();
    chk("R8", "head after first burst", ringHead, 8);
    chk("R9", "irq pulse", wbIrq, 1);
    @(negedge clk);
    chk("R9", "irq single cycle", wbIrq, 0);
    chk("R7", "follow-on issued", wrReq, 1);
    chk("R7", "follow-on count", wrCount, 4);
    chk("R7", "follow-on addr", wrAddr, 'h3080);
    wbFinish();
    chk("R8", "head after follow-on", ringHead, 12);

    // R10 legal reconfiguration clears the cache
    doReset();
    cfgWrite(2'd1, 64 * 16);
    cfgWrite(2'd3, 5);
    waitFetch(1'b1, fCnt, fAddr);
    chk("R5", "popValid with entries", popValid, 1);
    cfgWrite(2'd2, 9);
    chk("R10", "no error when idle", cfgErr, 0);
    chk("R10", "head written", ringHead, 9);
    chk("R10", "pool emptied", popValid, 0);
    chk("R10", "descLeft from pointer 0", descLeft, 5);
    waitFetch(1'b1, fCnt, fAddr);
    chk("R10", "refetch count", fCnt, 5);
    chk("R10", "refetch from index 0", fAddr, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule